// File: doc/BRIEF.md
# Boundary-Scan Sequencer Register Interface

This block is the processor-facing register file of an on-chip boundary-scan test sequencer. A simple memory-mapped bus, carrying an address, write data, a write flag, a select and a one-cycle acknowledge, reaches four 32-bit registers and two 64-word by 32-bit arrays. Software fills the program array, sets up the sequencer through the control register, and starts, steps, resumes or resets it through the execute register. The sequencer engine reads the program array through its own port and fills the result array through another port. Software then reads the status word and the recorded results.

The block decodes bus addresses and presents the control fields to the engine as levels. It turns execute writes into a run level plus single-cycle command pulses. It packs the engine's status signals into one readable word. It also owns the level interrupt. The engine itself, the test clock divider and the pin multiplexing are outside the block and appear here only as ports.

Top module: `tctl_regif`

## Requirements
- R1: After reset, the control register, the run level, every command pulse and the interrupt are all 0, so the sequencer stays idle and its test clock stays disabled until software writes the control register.
- R2: The control register at byte offset 0x200 stores write-data bits 12:0 and reads them back, with bits 31:13 reading as 0. The fields are mode in bits 3:0, clock divide in 6:4, clock enable in 7, single-step enable in 8, recording mode in 10:9, loop enable in 11 and interrupt enable in 12, and each field drives its own output port.
- R3: The program array occupies byte offsets 0x000–0x0FC, one word per 4 bytes. Bus writes store to word (offset/4), the engine read port returns that word combinationally, and bus reads of this region return 0.
- R4: The result array occupies byte offsets 0x100–0x1FC. The engine write port stores words into it, bus reads return them, and bus writes to it are ignored.
- R5: A read of the status word at 0x204 returns busy in bit 0, paused in bit 1, finished in bit 2, the current opcode in bits 6:3, the paused-in-data-shift flag in bit 7, the last result address in bits 13:8, the recorded-bit count in bits 25:14, and 0 in bits 31:26. The status word is read-only.
- R6: A read at 0x20C returns the engine's debug word. Writes there and to the status word are ignored.
- R7: A write to the execute register at 0x208 sets the run level to write-data bit 0. Bits 1, 2 and 3 each produce a single-cycle pulse (step, continue and engine reset). A read of the execute register returns the run level in bit 0 and 0 elsewhere.
- R8: When interrupt enable is set, a rising edge of the engine's finished signal or of its paused-in-data-shift signal raises the interrupt in the next cycle. When interrupt enable is clear, neither edge raises it.
- R9: An execute write with bit 0 clear drops the run level and clears a pending interrupt. An execute write with bit 0 set leaves a pending interrupt as it is.
- R10: A rising edge of the finished signal clears the run level when loop enable is clear, and leaves it set when loop enable is set.
- R11: When a stop write falls in the same cycle as a finished or pause edge, the clear wins and the interrupt stays low.
- R12: Every access is acknowledged exactly one cycle after the request cycle. A request is a cycle with select high and acknowledge low. Reads of unmapped or misaligned addresses return 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request, held until acknowledged |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle acknowledge |
| cfg_mode | output | 4 | Operating mode select |
| cfg_clk_div | output | 3 | Test clock divide select |
| cfg_clk_en | output | 1 | Test clock enable |
| cfg_step_en | output | 1 | Single-step mode |
| cfg_rec_mode | output | 2 | Output recording mode |
| cfg_loop | output | 1 | Loop mode |
| cfg_irq_en | output | 1 | Interrupt enable |
| run_o | output | 1 | Run level to engine |
| step_pulse | output | 1 | Execute one task |
| cont_pulse | output | 1 | Resume after pause |
| eng_rst_pulse | output | 1 | Reset the engine |
| eng_busy | input | 1 | Engine running |
| eng_paused | input | 1 | Engine paused |
| eng_done | input | 1 | Program finished |
| eng_opcode | input | 4 | Current task opcode |
| eng_shift_pause | input | 1 | Paused during data shift |
| eng_rec_addr | input | 6 | Last result address written |
| eng_rec_count | input | 12 | Recorded output bit count |
| eng_debug | input | 32 | Engine debug word |
| prog_raddr | input | 6 | Engine program read address |
| prog_rdata | output | 32 | Program word |
| res_we | input | 1 | Engine result write enable |
| res_waddr | input | 6 | Engine result write address |
| res_wdata | input | 32 | Engine result word |
| irq | output | 1 | Level interrupt |

## Verification
The interrupt's set path and its clear path can act in the same clock edge. This happens when software stops the sequencer with an execute write while the engine raises its finished or pause signal. The bench provokes this by raising the engine's finished input at the very negative edge on which it presents the stop write. Both events are therefore sampled at one rising edge. The bench then requires the interrupt to read low one cycle later and to stay low afterwards, since the finished level is held and no second edge can arrive. It also checks separately that the same edge raises the interrupt when no stop write is present.

// File: rtl/tctl_pkg.sv
// Package: shared field layout and region type for the sequencer register interface.
// Assumes the control register layout below is decoded by the engine side.
package tctl_pkg;

    localparam int DATA_W    = 32;
    localparam int CMD_W     = 4;    // execute command bits 3:0
    localparam int OPC_W     = 4;
    localparam int RADDR_W   = 6;
    localparam int RCOUNT_W  = 12;

    // Address region selected by the decoder
    typedef enum logic [2:0] {
        RGN_PROG,
        RGN_RES,
        RGN_CTRL,
        RGN_STAT,
        RGN_EXEC,
        RGN_DBG,
        RGN_NONE
    } rgn_e;

    // Control register, packed so bit 0 is mode[0] and bit 12 is irq_en
    typedef struct packed {
        logic       irq_en;
        logic       loop_en;
        logic [1:0] rec_mode;
        logic       step_en;
        logic       clk_en;
        logic [2:0] clk_div;
        logic [3:0] mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tctl_addr_dec.sv
// Module: tctl_addr_dec
// Maps a byte address to a region and a word index. Two arrays of 2**ARR_AW
// words sit below the register page; registers use word offsets 0..3 of the
// page; misaligned or unused addresses map to RGN_NONE.
module tctl_addr_dec
    import tctl_pkg::*;
#(
    parameter int ARR_AW = 6,
    parameter int ADDR_W = ARR_AW + 4
) (
    input  logic [ADDR_W-1:0] addr,
    output rgn_e              rgn,
    output logic [ARR_AW-1:0] widx
);

    // Purpose: region select from the top two address bits and the register page offset
    always_comb begin
        widx = addr[ARR_AW+1:2];
        rgn  = RGN_NONE;
        if (addr[1:0] == 2'b00) begin
            unique case (addr[ADDR_W-1:ADDR_W-2])
                2'b00: rgn = RGN_PROG;
                2'b01: rgn = RGN_RES;
                2'b10: begin
                    if (addr[ADDR_W-3:4] == '0) begin
                        unique case (addr[3:2])
                            2'b00: rgn = RGN_CTRL;
                            2'b01: rgn = RGN_STAT;
                            2'b10: rgn = RGN_EXEC;
                            default: rgn = RGN_DBG;
                        endcase
                    end
                end
                default: rgn = RGN_NONE;
            endcase
        end
    end

endmodule

// File: rtl/tctl_arrays.sv
// Module: tctl_arrays
// Holds the program array (bus write, engine read) and the result array
// (engine write, bus read). Both reads are combinational; contents are not reset.
module tctl_arrays #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              prog_we,
    input  logic [AW-1:0]     prog_waddr,
    input  logic [DATA_W-1:0] prog_wdata,
    input  logic [AW-1:0]     prog_raddr,
    output logic [DATA_W-1:0] prog_rdata,
    input  logic              res_we,
    input  logic [AW-1:0]     res_waddr,
    input  logic [DATA_W-1:0] res_wdata,
    input  logic [AW-1:0]     res_raddr,
    output logic [DATA_W-1:0] res_rdata
);

    logic [DATA_W-1:0] prog_mem [DEPTH];
    logic [DATA_W-1:0] res_mem  [DEPTH];

    // Purpose: store program words from the bus
    always_ff @(posedge clk) begin
        if (prog_we) prog_mem[prog_waddr] <= prog_wdata;
    end

    // Purpose: store result words from the engine
    always_ff @(posedge clk) begin
        if (res_we) res_mem[res_waddr] <= res_wdata;
    end

    // Purpose: combinational read ports
    always_comb begin
        prog_rdata = prog_mem[prog_raddr];
        res_rdata  = res_mem[res_raddr];
    end

endmodule

// File: rtl/tctl_ctrl_regs.sv
// Module: tctl_ctrl_regs
// Control register, run level, command pulses and level interrupt.
// Assumes at most one write strobe per cycle. A stop write takes priority
// over a coincident finished or pause edge.
module tctl_ctrl_regs
    import tctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_exec,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [CMD_W-1:0]  exec_cmd,
    input  logic              eng_done,
    input  logic              eng_shift_pause,
    output ctrl_t             ctrl_q,
    output logic              run_q,
    output logic              step_q,
    output logic              cont_q,
    output logic              erst_q,
    output logic              irq_q
);

    logic done_d1;
    logic spause_d1;
    logic done_rise;
    logic spause_rise;

    // Purpose: delay the engine event levels every cycle, reset included, for edge detection
    always_ff @(posedge clk) begin
        done_d1   <= eng_done;
        spause_d1 <= eng_shift_pause;
    end

    assign done_rise   = eng_done & ~done_d1;
    assign spause_rise = eng_shift_pause & ~spause_d1;

    // Purpose: control register storage
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(ctrl_wdata);
    end

    // Purpose: run level, set or cleared by software, dropped at finish outside loop mode
    always_ff @(posedge clk) begin
        if (!rst_n)                           run_q <= 1'b0;
        else if (wr_exec)                     run_q <= exec_cmd[0];
        else if (done_rise && !ctrl_q.loop_en) run_q <= 1'b0;
    end

    // Purpose: single-cycle command pulses from execute writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= 1'b0;
            cont_q <= 1'b0;
            erst_q <= 1'b0;
        end else begin
            step_q <= wr_exec & exec_cmd[1];
            cont_q <= wr_exec & exec_cmd[2];
            erst_q <= wr_exec & exec_cmd[3];
        end
    end

    // Purpose: level interrupt, stop write clears with priority over new events
    always_ff @(posedge clk) begin
        if (!rst_n)                                              irq_q <= 1'b0;
        else if (wr_exec && !exec_cmd[0])                        irq_q <= 1'b0;
        else if (ctrl_q.irq_en && (done_rise || spause_rise))    irq_q <= 1'b1;
    end

endmodule

// File: rtl/tctl_regif.sv
// Module: tctl_regif (top)
// Bus-facing register file of the boundary-scan sequencer. A request is a
// cycle with bus_sel high and bus_ack low; writes take effect at that edge
// and the acknowledge with read data follows one cycle later.
module tctl_regif
    import tctl_pkg::*;
#(
    parameter int ARR_DEPTH = 64,
    parameter int ADDR_W    = $clog2(ARR_DEPTH) + 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_ack,
    output logic [3:0]            cfg_mode,
    output logic [2:0]            cfg_clk_div,
    output logic                  cfg_clk_en,
    output logic                  cfg_step_en,
    output logic [1:0]            cfg_rec_mode,
    output logic                  cfg_loop,
    output logic                  cfg_irq_en,
    output logic                  run_o,
    output logic                  step_pulse,
    output logic                  cont_pulse,
    output logic                  eng_rst_pulse,
    input  logic                  eng_busy,
    input  logic                  eng_paused,
    input  logic                  eng_done,
    input  logic [OPC_W-1:0]      eng_opcode,
    input  logic                  eng_shift_pause,
    input  logic [RADDR_W-1:0]    eng_rec_addr,
    input  logic [RCOUNT_W-1:0]   eng_rec_count,
    input  logic [DATA_W-1:0]     eng_debug,
    input  logic [$clog2(ARR_DEPTH)-1:0] prog_raddr,
    output logic [DATA_W-1:0]     prog_rdata,
    input  logic                  res_we,
    input  logic [$clog2(ARR_DEPTH)-1:0] res_waddr,
    input  logic [DATA_W-1:0]     res_wdata,
    output logic                  irq
);

    localparam int ARR_AW  = $clog2(ARR_DEPTH);
    localparam int STAT_W  = 3 + OPC_W + 1 + RADDR_W + RCOUNT_W;

    logic              req;
    logic              wr_req;
    rgn_e              rgn;
    logic [ARR_AW-1:0] widx;
    logic [DATA_W-1:0] res_rd;
    logic [DATA_W-1:0] rd_mux;
    logic [STAT_W-1:0] stat_word;
    ctrl_t             ctrl_q;
    logic              run_q;

    assign req    = bus_sel & ~bus_ack;
    assign wr_req = req & bus_wr;

    tctl_addr_dec #(.ARR_AW(ARR_AW), .ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .rgn  (rgn),
        .widx (widx)
    );

    tctl_arrays #(.DEPTH(ARR_DEPTH), .DATA_W(DATA_W)) arr_i (
        .clk        (clk),
        .prog_we    (wr_req && rgn == RGN_PROG),
        .prog_waddr (widx),
        .prog_wdata (bus_wdata),
        .prog_raddr (prog_raddr),
        .prog_rdata (prog_rdata),
        .res_we     (res_we),
        .res_waddr  (res_waddr),
        .res_wdata  (res_wdata),
        .res_raddr  (widx),
        .res_rdata  (res_rd)
    );

    tctl_ctrl_regs ctl_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_ctrl         (wr_req && rgn == RGN_CTRL),
        .wr_exec         (wr_req && rgn == RGN_EXEC),
        .ctrl_wdata      (bus_wdata[CTRL_W-1:0]),
        .exec_cmd        (bus_wdata[CMD_W-1:0]),
        .eng_done        (eng_done),
        .eng_shift_pause (eng_shift_pause),
        .ctrl_q          (ctrl_q),
        .run_q           (run_q),
        .step_q          (step_pulse),
        .cont_q          (cont_pulse),
        .erst_q          (eng_rst_pulse),
        .irq_q           (irq)
    );

    // Purpose: fan the control fields out to the engine
    always_comb begin
        cfg_mode     = ctrl_q.mode;
        cfg_clk_div  = ctrl_q.clk_div;
        cfg_clk_en   = ctrl_q.clk_en;
        cfg_step_en  = ctrl_q.step_en;
        cfg_rec_mode = ctrl_q.rec_mode;
        cfg_loop     = ctrl_q.loop_en;
        cfg_irq_en   = ctrl_q.irq_en;
        run_o        = run_q;
    end

    assign stat_word = {eng_rec_count, eng_rec_addr, eng_shift_pause,
                        eng_opcode, eng_done, eng_paused, eng_busy};

    // Purpose: select read data by region
    always_comb begin
        unique case (rgn)
            RGN_RES:  rd_mux = res_rd;
            RGN_CTRL: rd_mux = DATA_W'(ctrl_q);
            RGN_STAT: rd_mux = DATA_W'(stat_word);
            RGN_EXEC: rd_mux = DATA_W'(run_q);
            RGN_DBG:  rd_mux = eng_debug;
            default:  rd_mux = '0;
        endcase
    end

    // Purpose: one-cycle acknowledge with registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack   <= req;
            bus_rdata <= (req && !bus_wr) ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/tctl_regif_chk.sv
// Module: tctl_regif_chk
// Temporal checks on the register interface, bound into every tctl_regif.
module tctl_regif_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wd0,
    input logic              wd1,
    input logic              bus_ack,
    input logic              step_pulse,
    input logic              run_o,
    input logic              irq,
    input logic              cfg_irq_en,
    input logic              cfg_loop,
    input logic              eng_done
);

    localparam logic [ADDR_W-1:0] EXEC_A = ADDR_W'((2 << (ADDR_W - 2)) + 8);

    logic exec_wr;
    assign exec_wr = bus_sel && !bus_ack && bus_wr && (bus_addr == EXEC_A);

    // R12
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_ack) |=> bus_ack);

    // R12
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R7
    step_from_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> $past(exec_wr && wd1));

    // R9
    stop_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_wr && !wd0) |=> !irq);

    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cfg_irq_en));

    // R10
    run_autostop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(eng_done) && !cfg_loop && !exec_wr) |=> !run_o);

endmodule

bind tctl_regif tctl_regif_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wd0        (bus_wdata[0]),
    .wd1        (bus_wdata[1]),
    .bus_ack    (bus_ack),
    .step_pulse (step_pulse),
    .run_o      (run_o),
    .irq        (irq),
    .cfg_irq_en (cfg_irq_en),
    .cfg_loop   (cfg_loop),
    .eng_done   (eng_done)
);

// File: tb/tctl_regif_tb_top.sv
// Bench: scoreboard. The read task pushes expected words into a queue and the
// monitor pops and compares them when the acknowledge arrives.
module tctl_regif_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic [3:0]  cfg_mode;
    logic [2:0]  cfg_clk_div;
    logic        cfg_clk_en, cfg_step_en, cfg_loop, cfg_irq_en;
    logic [1:0]  cfg_rec_mode;
    logic        run_o, step_pulse, cont_pulse, eng_rst_pulse, irq;
    logic        eng_busy = 0, eng_paused = 0, eng_done = 0, eng_shift_pause = 0;
    logic [3:0]  eng_opcode = '0;
    logic [5:0]  eng_rec_addr = '0;
    logic [11:0] eng_rec_count = '0;
    logic [31:0] eng_debug = '0;
    logic [5:0]  prog_raddr = '0;
    logic [31:0] prog_rdata;
    logic        res_we = 0;
    logic [5:0]  res_waddr = '0;
    logic [31:0] res_wdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_inflight = 0;
    logic [2:0]  pulses_seen;   // {erst, cont, step} at acknowledge

    always #2 clk = ~clk;

    tctl_regif dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .cfg_mode(cfg_mode), .cfg_clk_div(cfg_clk_div),
        .cfg_clk_en(cfg_clk_en), .cfg_step_en(cfg_step_en),
        .cfg_rec_mode(cfg_rec_mode), .cfg_loop(cfg_loop), .cfg_irq_en(cfg_irq_en),
        .run_o(run_o), .step_pulse(step_pulse), .cont_pulse(cont_pulse),
        .eng_rst_pulse(eng_rst_pulse), .eng_busy(eng_busy), .eng_paused(eng_paused),
        .eng_done(eng_done), .eng_opcode(eng_opcode), .eng_shift_pause(eng_shift_pause),
        .eng_rec_addr(eng_rec_addr), .eng_rec_count(eng_rec_count),
        .eng_debug(eng_debug), .prog_raddr(prog_raddr), .prog_rdata(prog_rdata),
        .res_we(res_we), .res_waddr(res_waddr), .res_wdata(res_wdata), .irq(irq)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Monitor: compares read data against the scoreboard at each read acknowledge
    always @(negedge clk) begin
        if (bus_ack && rd_inflight) begin
            rd_inflight = 0;
            if (exp_q.size() == 0) check(0, "scoreboard empty", bus_rdata, '0);
            else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d,
                             input bit raise_done = 0);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        if (raise_done) eng_done = 1;
        @(negedge clk);
        pulses_seen = {eng_rst_pulse, cont_pulse, step_pulse};
        check(bus_ack === 1'b1, "R12 write ack", 32'(bus_ack), 32'd1);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [9:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_inflight = 1;
        @(negedge clk);
        bus_sel = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", '0, '0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check({cfg_clk_en, run_o, irq, step_pulse, cont_pulse, eng_rst_pulse, cfg_mode} === '0,
              "R1 reset outputs", 32'({cfg_clk_en, run_o, irq, cfg_mode}), 32'd0);
        bus_read(10'h200, 32'h0, "R1 control after reset");
        bus_read(10'h208, 32'h0, "R1 execute after reset");

        // R2 control fields
        bus_write(10'h200, 32'hFFFF_E000 | 32'h1A5B);
        bus_read(10'h200, 32'h0000_1A5B, "R2 control readback");
        check({cfg_irq_en, cfg_loop, cfg_rec_mode, cfg_step_en, cfg_clk_en, cfg_clk_div, cfg_mode} === 13'h1A5B,
              "R2 control fields", 32'({cfg_irq_en, cfg_loop, cfg_rec_mode, cfg_step_en,
              cfg_clk_en, cfg_clk_div, cfg_mode}), 32'h1A5B);
        bus_write(10'h200, 32'h0000_0000);

        // R3 program array
        bus_write(10'h014, 32'hCAFE_0005);
        bus_write(10'h0FC, 32'h1234_003F);
        prog_raddr = 6'd5; #1;
        check(prog_rdata === 32'hCAFE_0005, "R3 program word 5", prog_rdata, 32'hCAFE_0005);
        prog_raddr = 6'd63; #1;
        check(prog_rdata === 32'h1234_003F, "R3 program word 63", prog_rdata, 32'h1234_003F);
        bus_read(10'h014, 32'h0, "R3 program not readable");

        // R4 result array
        @(negedge clk);
        res_we = 1; res_waddr = 6'd7; res_wdata = 32'h0BAD_F00D;
        @(negedge clk);
        res_we = 0;
        bus_read(10'h11C, 32'h0BAD_F00D, "R4 result read");
        bus_write(10'h11C, 32'h5555_5555);
        bus_read(10'h11C, 32'h0BAD_F00D, "R4 result write ignored");

        // R5 status packing
        eng_busy = 1; eng_paused = 1; eng_opcode = 4'hA; eng_rec_addr = 6'h2D;
        eng_rec_count = 12'hABC;
        bus_read(10'h204, (32'hABC << 14) | (32'h2D << 8) | (32'hA << 3) | 32'h3, "R5 status word");
        bus_write(10'h204, 32'hFFFF_FFFF);
        bus_read(10'h204, (32'hABC << 14) | (32'h2D << 8) | (32'hA << 3) | 32'h3, "R5 status read-only");
        eng_busy = 0; eng_paused = 0;

        // R6 debug
        eng_debug = 32'hDEB0_0001;
        bus_write(10'h20C, 32'h0);
        bus_read(10'h20C, 32'hDEB0_0001, "R6 debug readback");

        // R7 execute commands
        bus_write(10'h208, 32'h3);
        check(pulses_seen === 3'b001, "R7 step pulse", 32'(pulses_seen), 32'b001);
        @(negedge clk);
        check(step_pulse === 1'b0, "R7 step single cycle", 32'(step_pulse), 32'd0);
        bus_read(10'h208, 32'h1, "R7 execute reads run only");
        bus_write(10'h208, 32'h5);
        check(pulses_seen === 3'b010, "R7 continue pulse", 32'(pulses_seen), 32'b010);
        bus_write(10'h208, 32'h8);
        check(pulses_seen === 3'b100 && run_o === 1'b0, "R7 engine reset pulse",
              32'({pulses_seen, run_o}), 32'b1000);

        // R8 / R10 finish edge with interrupt enable, no loop
        bus_write(10'h200, 32'h1000);
        bus_write(10'h208, 32'h1);
        @(negedge clk); eng_done = 1;
        @(negedge clk);
        check(irq === 1'b1, "R8 irq on finish", 32'(irq), 32'd1);
        check(run_o === 1'b0, "R10 run cleared on finish", 32'(run_o), 32'd0);
        eng_done = 0;
        // R9 start write keeps irq, stop write clears it
        bus_write(10'h208, 32'h1);
        check(irq === 1'b1, "R9 start keeps irq", 32'(irq), 32'd1);
        bus_write(10'h208, 32'h0);
        check(irq === 1'b0, "R9 stop clears irq", 32'(irq), 32'd0);

        // R8 pause during data shift
        @(negedge clk); eng_shift_pause = 1;
        @(negedge clk);
        check(irq === 1'b1, "R8 irq on shift pause", 32'(irq), 32'd1);
        eng_shift_pause = 0;
        bus_write(10'h208, 32'h0);

        // R8 disabled interrupt
        bus_write(10'h200, 32'h0);
        @(negedge clk); eng_done = 1;
        @(negedge clk); @(negedge clk);
        check(irq === 1'b0, "R8 no irq when disabled", 32'(irq), 32'd0);
        eng_done = 0;

        // R10 loop mode keeps running
        bus_write(10'h200, 32'h0800);
        bus_write(10'h208, 32'h1);
        @(negedge clk); eng_done = 1;
        @(negedge clk);
        check(run_o === 1'b1, "R10 loop keeps run", 32'(run_o), 32'd1);
        eng_done = 0;

        // R11 stop write coincident with finish edge
        bus_write(10'h200, 32'h1000);
        bus_write(10'h208, 32'h1);
        bus_write(10'h208, 32'h0, 1);
        check(irq === 1'b0, "R11 clear wins at collision", 32'(irq), 32'd0);
        @(negedge clk);
        check(irq === 1'b0 && run_o === 1'b0, "R11 irq stays low", 32'({irq, run_o}), 32'd0);
        eng_done = 0;

        // R12 unmapped and misaligned
        bus_read(10'h210, 32'h0, "R12 unmapped page offset");
        bus_read(10'h302, 32'h0, "R12 top region");
        bus_read(10'h201, 32'h0, "R12 misaligned");

        @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'd0);
        summary();
        $finish;
    end

endmodule